// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block collects 64 level-sensitive interrupt request lines and selects one winner. Each line is qualified by a software force bit, a mask bit and a programmable per-source priority byte. The winner's priority is driven to the processor as an interrupt level, together with a vector number derived from the winning source's index. When nothing qualifies, the level is zero and a fixed "no interrupt" vector is shown.

Software reaches the block over a simple synchronous register bus. A small two-state access machine handles each transfer. In state `BS_IDLE` a request is accepted (transition *accept*), and any write takes effect on that clock edge. The machine then moves to `BS_RESP`. There, for exactly one cycle, it presents the acknowledge, the read data and the error flag, and it returns to `BS_IDLE` unconditionally (transition *release*). A request that arrives in `BS_RESP` is not taken.

Through the bus, software can read the request lines and read or write the mask and force words. It can write any priority byte, mask or unmask one source or all sources with a single byte write, and read the current vector as a software acknowledge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask is all ones, the force bits and every priority byte are zero, `irq_level` is 0 and `irq_vector` is 24.
- R2: Source n competes only when (request n OR force n) is 1, its priority byte is nonzero, and its mask bit is 0.
- R3: Among competing sources the highest priority byte wins; on equal priority the higher index wins. `irq_vector` = 64 + winning index and `irq_level` = its priority. With no competitor, the level is 0 and the vector is 24.
- R4: `irq_level` and `irq_vector` are registered. They reflect the request lines and register state as sampled at the previous clock edge.
- R5: A write to offset 0x40+n stores bits [7:0] as the priority of source n, and a read there returns it. Priority zero disables the source.
- R6: A read at 0x00 returns request lines 63:32 and a read at 0x04 returns lines 31:0. Writes to either offset change nothing and raise no error.
- R7: Mask is read/write at 0x08 (sources 63:32) and 0x0C (31:0). Force is read/write at 0x10 (63:32) and 0x14 (31:0). A mask bit of 1 blocks its source.
- R8: A write to 0x1C sets the mask bit selected by data bits [5:0]. If data bit 6 is 1, it sets all 64 mask bits instead.
- R9: A write to 0x1D clears the mask bit selected by data bits [5:0]. If data bit 6 is 1, it clears all 64 mask bits instead.
- R10: A read at 0xE0 returns the current `irq_vector`. A read of any other unlisted offset returns 0 without error.
- R11: A write to an offset other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x1C, 0x1D or 0x40–0x7F, and a read at 0xE1–0xE7, both raise `bus_err` together with `bus_ack` for one cycle and change no state.
- R12: A request taken in `BS_IDLE` is answered with `bus_ack` high for exactly one cycle, starting on the next cycle. A request present during that response cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 64 | Level-sensitive request lines |
| bus_req | input | 1 | Transfer request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response valid for one cycle |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_err | output | 1 | Error flag, valid with `bus_ack` |
| irq_level | output | LVL_W | Winning priority, 0 when idle |
| irq_vector | output | VEC_W | Winning vector |

## Verification
The bench builds the block with its default parameters: 8-bit priorities, vector base 64 and idle vector 24. With these values every source index can be swept one at a time, with the vector and level checked arithmetically against 64+n and n mod 7 + 1. Loading that same priority pattern on all 64 sources at once exposes the tie rule, because several sources share the top priority. Masking or disabling the current winner then shows the next-best source taking over, and the force path, the read-only request words and every error offset class are each probed at the bus.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int NSRC  = 64;
    localparam int IDX_W = $clog2(NSRC);

    typedef enum logic {BS_IDLE = 1'b0, BS_RESP = 1'b1} bus_state_e;

    localparam logic [7:0] OFS_PEND_HI = 8'h00;
    localparam logic [7:0] OFS_PEND_LO = 8'h04;
    localparam logic [7:0] OFS_MASK_HI = 8'h08;
    localparam logic [7:0] OFS_MASK_LO = 8'h0C;
    localparam logic [7:0] OFS_FRC_HI  = 8'h10;
    localparam logic [7:0] OFS_FRC_LO  = 8'h14;
    localparam logic [7:0] OFS_MSET    = 8'h1C;
    localparam logic [7:0] OFS_MCLR    = 8'h1D;
    localparam logic [7:0] OFS_SWACK   = 8'hE0;
endpackage

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic [31:0] rd_data,
    input  logic        rd_err,
    input  logic        wr_err,
    input  logic        we,
    output logic        accept,
    output logic        ack,
    output logic [31:0] rdata,
    output logic        err
);
    bus_state_e state_q, state_d;

    assign accept = (state_q == BS_IDLE) && req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE: if (req) state_d = BS_RESP;
            BS_RESP: state_d = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            ack   <= accept;
            rdata <= (accept && !we) ? rd_data : '0;
            err   <= accept && (we ? wr_err : rd_err);
        end
    end

    a_r12_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    a_r12_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> ack);
    a_r11_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ack);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_ctrl_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            addr,
    input  logic [31:0]           wdata,
    output logic [NSRC-1:0]       mask_q,
    output logic [NSRC-1:0]       force_q,
    output logic [NSRC*LVL_W-1:0] lvl_flat,
    output logic                  wr_bad
);
    localparam logic [NSRC-1:0] ONE = {{(NSRC-1){1'b0}}, 1'b1};

    logic lvl_zone;
    assign lvl_zone = (addr[7:6] == 2'b01);

    always_comb begin
        unique case (addr)
            OFS_PEND_HI, OFS_PEND_LO, OFS_MASK_HI, OFS_MASK_LO,
            OFS_FRC_HI, OFS_FRC_LO, OFS_MSET, OFS_MCLR: wr_bad = 1'b0;
            default: wr_bad = !lvl_zone;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            force_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFS_MASK_HI: mask_q[63:32]  <= wdata;
                OFS_MASK_LO: mask_q[31:0]   <= wdata;
                OFS_FRC_HI:  force_q[63:32] <= wdata;
                OFS_FRC_LO:  force_q[31:0]  <= wdata;
                OFS_MSET: begin
                    if (wdata[6]) mask_q <= '1;
                    else          mask_q <= mask_q | (ONE << wdata[IDX_W-1:0]);
                end
                OFS_MCLR: begin
                    if (wdata[6]) mask_q <= '0;
                    else          mask_q <= mask_q & ~(ONE << wdata[IDX_W-1:0]);
                end
                default: ;
            endcase
        end
    end

    for (genvar n = 0; n < NSRC; n++) begin : g_lvl
        logic [LVL_W-1:0] lvl_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q <= '0;
            else if (wr_en && lvl_zone && addr[IDX_W-1:0] == IDX_W'(n))
                lvl_q <= wdata[LVL_W-1:0];
        end
        assign lvl_flat[n*LVL_W +: LVL_W] = lvl_q;
    end

    a_r6_pend_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFS_PEND_HI || addr == OFS_PEND_LO))
        |=> ($stable(mask_q) && $stable(force_q) && $stable(lvl_flat)));
    a_r8_set_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_MSET && wdata[6]) |=> (&mask_q));
    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_MCLR && wdata[6]) |=> (mask_q == '0));
    a_r11_bad_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bad) |=> ($stable(mask_q) && $stable(force_q) && $stable(lvl_flat)));
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_ctrl_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic [NSRC-1:0]       active,
    input  logic [NSRC*LVL_W-1:0] lvl_flat,
    output logic [LVL_W-1:0]      win_lvl,
    output logic [IDX_W-1:0]      win_idx,
    output logic                  win_any
);
    always_comb begin
        win_lvl = '0;
        win_idx = '0;
        win_any = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (active[i] && lvl_flat[i*LVL_W +: LVL_W] >= win_lvl) begin
                win_lvl = lvl_flat[i*LVL_W +: LVL_W];
                win_idx = IDX_W'(i);
                win_any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int LVL_W    = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int VEC_NONE = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [63:0]      irq_req,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic             bus_ack,
    output logic [31:0]      bus_rdata,
    output logic             bus_err,
    output logic [LVL_W-1:0] irq_level,
    output logic [VEC_W-1:0] irq_vector
);
    logic                  accept, wr_bad, win_any;
    logic [NSRC-1:0]       mask_q, force_q, enable, active;
    logic [NSRC*LVL_W-1:0] lvl_flat;
    logic [LVL_W-1:0]      win_lvl;
    logic [IDX_W-1:0]      win_idx;
    logic [31:0]           rd_data;
    logic                  rd_err;

    irq_regs #(.LVL_W(LVL_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(accept && bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .mask_q(mask_q), .force_q(force_q),
        .lvl_flat(lvl_flat), .wr_bad(wr_bad)
    );

    for (genvar n = 0; n < NSRC; n++) begin : g_en
        assign enable[n] = |lvl_flat[n*LVL_W +: LVL_W];
    end

    assign active = (irq_req | force_q) & enable & ~mask_q;

    irq_pick #(.LVL_W(LVL_W)) pick_i (
        .active(active), .lvl_flat(lvl_flat),
        .win_lvl(win_lvl), .win_idx(win_idx), .win_any(win_any)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level  <= '0;
            irq_vector <= VEC_W'(VEC_NONE);
        end else begin
            irq_level  <= win_any ? win_lvl : '0;
            irq_vector <= win_any ? VEC_W'(VEC_BASE + int'(win_idx)) : VEC_W'(VEC_NONE);
        end
    end

    always_comb begin
        rd_data = '0;
        rd_err  = 1'b0;
        if (bus_addr[7:6] == 2'b01) begin
            rd_data = 32'(lvl_flat[int'(bus_addr[IDX_W-1:0])*LVL_W +: LVL_W]);
        end else begin
            unique case (bus_addr)
                OFS_PEND_HI: rd_data = irq_req[63:32];
                OFS_PEND_LO: rd_data = irq_req[31:0];
                OFS_MASK_HI: rd_data = mask_q[63:32];
                OFS_MASK_LO: rd_data = mask_q[31:0];
                OFS_FRC_HI:  rd_data = force_q[63:32];
                OFS_FRC_LO:  rd_data = force_q[31:0];
                OFS_SWACK:   rd_data = 32'(irq_vector);
                8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5, 8'hE6, 8'hE7: rd_err = 1'b1;
                default: ;
            endcase
        end
    end

    irq_bus_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .rd_data(rd_data),
        .rd_err(rd_err), .wr_err(wr_bad), .we(bus_we), .accept(accept),
        .ack(bus_ack), .rdata(bus_rdata), .err(bus_err)
    );

    a_r3_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) |-> (irq_vector == VEC_W'(VEC_NONE)));
    a_r3_busy_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (irq_vector >= VEC_W'(VEC_BASE)));
    a_r2_masked_all_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |=> (irq_level == '0));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_req = '0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_level, irq_vector;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er, output logic ak);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        rd = bus_rdata; er = bus_err; ak = bus_ack;
        @(negedge clk);
    endtask

    function automatic int lvl_of(input int i);
        return (i % 7) + 1;
    endfunction

    task automatic settle();
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        logic er, ak;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 level", 32'(irq_level), 0);
        chk("R1 vector", 32'(irq_vector), 24);
        xfer(0, 8'h08, 0, rd, er, ak); chk("R1 mask hi", rd, 32'hFFFF_FFFF);
        xfer(0, 8'h0C, 0, rd, er, ak); chk("R1 mask lo", rd, 32'hFFFF_FFFF);
        xfer(0, 8'h14, 0, rd, er, ak); chk("R1 force lo", rd, 0);
        xfer(0, 8'h45, 0, rd, er, ak); chk("R1 prio byte", rd, 0);

        // R5 priority bytes
        for (int i = 0; i < 64; i++) begin
            xfer(1, 8'(8'h40 + i), 32'hFFFF_FF00 | 32'(lvl_of(i)), rd, er, ak);
            xfer(0, 8'(8'h40 + i), 0, rd, er, ak);
            chk("R5 prio readback", rd, 32'(lvl_of(i)));
        end

        // R9 clear all, R2 no request => quiet
        xfer(1, 8'h1D, 32'h40, rd, er, ak);
        xfer(0, 8'h08, 0, rd, er, ak); chk("R9 mask hi cleared", rd, 0);
        xfer(0, 8'h0C, 0, rd, er, ak); chk("R9 mask lo cleared", rd, 0);
        chk("R2 no request level", 32'(irq_level), 0);

        // R2 R3 single-source sweep
        for (int i = 0; i < 64; i++) begin
            irq_req = 64'd1 << i;
            settle();
            chk("R3 sweep vector", 32'(irq_vector), 32'(64 + i));
            chk("R3 sweep level", 32'(irq_level), 32'(lvl_of(i)));
        end
        irq_req = '0;
        settle();

        // R4 registered timing
        @(negedge clk);
        irq_req = 64'd1 << 10;
        #1;
        chk("R4 unchanged before edge", 32'(irq_vector), 24);
        @(negedge clk);
        chk("R4 updated after one edge", 32'(irq_vector), 74);

        // R3 tie: top priority 7 at 6,13,...,62
        irq_req = '1;
        settle();
        chk("R3 tie vector", 32'(irq_vector), 126);
        chk("R3 tie level", 32'(irq_level), 7);

        // R8 mask single source 62
        xfer(1, 8'h1C, 32'd62, rd, er, ak);
        chk("R8 next winner", 32'(irq_vector), 119);
        xfer(0, 8'h08, 0, rd, er, ak); chk("R8 mask hi bit", rd, 32'h4000_0000);

        // R5 disable source 55 by zero priority
        xfer(1, 8'h40 + 8'd55, 0, rd, er, ak);
        chk("R5 disabled source", 32'(irq_vector), 112);
        // R10 software acknowledge read
        xfer(0, 8'hE0, 0, rd, er, ak); chk("R10 vector read", rd, 112);

        // R9 single clear restores 62
        xfer(1, 8'h1D, 32'd62, rd, er, ak);
        chk("R9 single unmask", 32'(irq_vector), 126);

        // R7 force path
        irq_req = '0;
        settle();
        chk("R3 none vector", 32'(irq_vector), 24);
        xfer(1, 8'h14, 32'h8, rd, er, ak);
        chk("R7 force vector", 32'(irq_vector), 67);
        chk("R7 force level", 32'(irq_level), 4);
        xfer(0, 8'h14, 0, rd, er, ak); chk("R7 force readback", rd, 32'h8);
        xfer(1, 8'h14, 0, rd, er, ak);
        xfer(1, 8'h10, 32'hDEAD_0001, rd, er, ak);
        xfer(0, 8'h10, 0, rd, er, ak); chk("R7 force hi readback", rd, 32'hDEAD_0001);
        xfer(1, 8'h10, 0, rd, er, ak);

        // R6 pending read-only
        irq_req = 64'hA5A5_0F0F_1234_8001;
        xfer(0, 8'h00, 0, rd, er, ak); chk("R6 pend hi", rd, 32'hA5A5_0F0F);
        xfer(0, 8'h04, 0, rd, er, ak); chk("R6 pend lo", rd, 32'h1234_8001);
        xfer(1, 8'h04, 32'hFFFF_FFFF, rd, er, ak); chk("R6 write no error", 32'(er), 0);
        xfer(0, 8'h04, 0, rd, er, ak); chk("R6 pend lo after write", rd, 32'h1234_8001);

        // R8 set all, R2 masked => quiet
        xfer(1, 8'h1C, 32'h40, rd, er, ak);
        chk("R8 all masked level", 32'(irq_level), 0);
        chk("R8 all masked vector", 32'(irq_vector), 24);
        xfer(0, 8'h08, 0, rd, er, ak); chk("R8 mask hi all", rd, 32'hFFFF_FFFF);
        xfer(0, 8'h0C, 0, rd, er, ak); chk("R8 mask lo all", rd, 32'hFFFF_FFFF);

        // R7 mask word write
        xfer(1, 8'h0C, 32'h0000_F00F, rd, er, ak);
        xfer(0, 8'h0C, 0, rd, er, ak); chk("R7 mask lo rw", rd, 32'h0000_F00F);
        xfer(1, 8'h0C, 32'hFFFF_FFFF, rd, er, ak);

        // R10 unmapped reads
        xfer(0, 8'h20, 0, rd, er, ak);
        chk("R10 unmapped data", rd, 0); chk("R10 unmapped err", 32'(er), 0);
        xfer(0, 8'hF0, 0, rd, er, ak); chk("R10 unmapped F0", rd, 0);

        // R11 errors
        xfer(1, 8'h20, 32'h0, rd, er, ak);
        chk("R11 bad write err", 32'(er), 1); chk("R11 bad write ack", 32'(ak), 1);
        xfer(0, 8'h0C, 0, rd, er, ak); chk("R11 mask unchanged", rd, 32'hFFFF_FFFF);
        xfer(1, 8'hE0, 32'h0, rd, er, ak); chk("R11 write to E0 err", 32'(er), 1);
        xfer(0, 8'hE3, 0, rd, er, ak); chk("R11 read E3 err", 32'(er), 1);
        xfer(0, 8'hE7, 0, rd, er, ak); chk("R11 read E7 err", 32'(er), 1);

        // R12 held request: accepted every other cycle
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'hE0;
        @(negedge clk); chk("R12 ack first", 32'(bus_ack), 1);
        @(negedge clk); chk("R12 ack drops", 32'(bus_ack), 0);
        @(negedge clk); chk("R12 ack again", 32'(bus_ack), 1);
        bus_req = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule